// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock Core

This core keeps time as a 32-bit count of seconds. A free-running enable of 32.768 kHz feeds a prescaler. Each time the prescaler fills, it produces a one-second tick, and the tick advances the seconds count. Three sticky status flags mark the count's condition. The invalid flag means the count has never been loaded. The overflow flag means the count has wrapped past its top. The alarm flag means the count has reached a programmed match value. While the invalid or overflow flag is set, counting is frozen. Software must stop the counter and load a fresh value, and that load clears both flags.

Software reaches the core through a simple synchronous register bus with address, write enable, write data and combinational read data. Four interrupt enables gate the three flags and a per-second pulse onto a single interrupt line. A soft-reset bit holds every other register at its reset value for as long as it stays set. A compensation word is only stored and read back.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset the seconds count reads 0, the status register reads 1 (only the invalid flag set), and control, interrupt-enable, alarm and compensation registers read 0; irq_o is low.
- R2: While counting is allowed, one tick occurs on every 2^PRESC_BITS-th accepted step_i pulse. While counting is not allowed, the prescaler returns to zero, so a full 2^PRESC_BITS steps are needed after counting resumes.
- R3: The seconds count advances by one on a tick only while control bit 0 (count enable) is 1 and status bit 0 (invalid) and bit 1 (overflow) are both 0.
- R4: A write to the seconds register (address 0) is ignored while count enable is 1. When count enable is 0, the write loads the value and clears the invalid and overflow flags.
- R5: A tick taken at count 0xFFFFFFFF makes the count read 0 and sets status bit 1. Counting then stays stopped.
- R6: Status bit 2 (alarm) sets on the tick that makes the seconds count equal the alarm register (address 1). Any write to the alarm register clears it.
- R7: irq_o is the OR of (invalid AND ien bit 0), (overflow AND ien bit 1) and (alarm AND ien bit 2), together with a one-cycle pulse after each tick while ien bit 3 is set. The interrupt-enable register is at address 4.
- R8: While control bit 1 (soft reset) is 1, every other register is held at its R1 value and writes to them are lost. The bit itself stays 1 until software writes control with bit 1 at 0.
- R9: The compensation register (address 5) stores and returns any 32-bit value and has no effect on counting.
- R10: The status register is at address 2 and the control register at address 3. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One-cycle 32.768 kHz timebase enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle, assertions check the following:
- the seconds count holds when no tick and no accepted write occur;
- a write made while the counter is enabled leaves the count unchanged;
- a wrap sets the overflow flag;
- the prescaler stays cleared while counting is not allowed;
- the alarm flag rises only with a tick and drops after an alarm write;
- soft reset keeps the other registers at their reset values and stays sticky.

Only the bench's scenarios can show the observable cases:
- the exact number of steps per tick;
- the freeze caused by an unloaded count and by overflow;
- alarm matching against a real count;
- the width of the seconds interrupt pulse;
- the compensation round trip.

A behavioural model compares read data and irq_o against the design on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int IEN_W  = 4;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ALM  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;
  localparam logic [ADDR_W-1:0] A_COMP = 3'd5;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_SWR = 1;
  localparam int IEN_SEC  = 3;

  // bit order matches status register: [2]=alarm [1]=ovf [0]=inv
  typedef struct packed {
    logic alarm;
    logic ovf;
    logic inv;
  } rtc_flags_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_BITS = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic step_i,
  output logic tick_o
);
  localparam logic [PRESC_BITS-1:0] CNT_MAX = '1;

  logic [PRESC_BITS-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || !run_i) cnt_q <= '0;
    else if (step_i)            cnt_q <= cnt_q + PRESC_BITS'(1);
  end

  assign tick_o = run_i && step_i && (cnt_q == CNT_MAX);

  // R2
  presc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [SEC_W-1:0] wdata_i,
  output logic [SEC_W-1:0] sec_o,
  output logic             inv_o,
  output logic             ovf_o
);
  localparam logic [SEC_W-1:0] SEC_MAX = '1;

  logic [SEC_W-1:0] sec_q;
  logic             inv_q, ovf_q;
  logic             load;

  assign load = wr_i && !en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      inv_q <= 1'b1;
      ovf_q <= 1'b0;
    end else if (clear_i) begin
      sec_q <= '0;
      inv_q <= 1'b1;
      ovf_q <= 1'b0;
    end else if (load) begin
      sec_q <= wdata_i;
      inv_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (tick_i) begin
      sec_q <= sec_q + SEC_W'(1);
      if (sec_q == SEC_MAX) ovf_q <= 1'b1;
    end
  end

  assign sec_o = sec_q;
  assign inv_o = inv_q;
  assign ovf_o = ovf_q;

  // R3
  sec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load && !clear_i) |=> $stable(sec_q));
  // R4
  sec_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && en_i && !tick_i && !clear_i) |=> $stable(sec_q));
  // R5
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clear_i && !load && sec_q == SEC_MAX) |=> (ovf_q && sec_q == '0));
  // R8
  sec_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (inv_q && !ovf_q && sec_q == '0));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [SEC_W-1:0] wdata_i,
  input  logic [SEC_W-1:0] sec_i,
  output logic [SEC_W-1:0] alarm_o,
  output logic             flag_o
);
  logic [SEC_W-1:0] alarm_q, sec_nxt;
  logic             flag_q;

  assign sec_nxt = sec_i + SEC_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      flag_q  <= 1'b0;
    end else if (clear_i) begin
      alarm_q <= '0;
      flag_q  <= 1'b0;
    end else if (wr_i) begin
      alarm_q <= wdata_i;
      flag_q  <= 1'b0;
    end else if (tick_i && sec_nxt == alarm_q) begin
      flag_q  <= 1'b1;
    end
  end

  assign alarm_o = alarm_q;
  assign flag_o  = flag_q;

  // R6
  alarm_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_i));
  // R6
  alarm_wrclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !flag_q);
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_pkg::*;
#(
  parameter int PRESC_BITS = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              en_q, swr_q, sec_pulse_q;
  logic [IEN_W-1:0]  ien_q;
  logic [DATA_W-1:0] comp_q, sec_w, alarm_w;
  rtc_flags_t        flags;
  logic              run, tick;
  logic              wr_sec, wr_alm, wr_ctrl, wr_ien, wr_comp;

  assign wr_sec  = we_i && addr_i == A_SEC  && !swr_q;
  assign wr_alm  = we_i && addr_i == A_ALM  && !swr_q;
  assign wr_ctrl = we_i && addr_i == A_CTRL;
  assign wr_ien  = we_i && addr_i == A_IEN  && !swr_q;
  assign wr_comp = we_i && addr_i == A_COMP && !swr_q;

  assign run = en_q && !flags.inv && !flags.ovf;

  rtc_prescaler #(.PRESC_BITS(PRESC_BITS)) presc_i (
    .clk_i, .rst_ni, .clear_i(swr_q), .run_i(run), .step_i, .tick_o(tick)
  );

  rtc_seconds #(.SEC_W(DATA_W)) secs_i (
    .clk_i, .rst_ni, .clear_i(swr_q), .tick_i(tick), .en_i(en_q),
    .wr_i(wr_sec), .wdata_i, .sec_o(sec_w), .inv_o(flags.inv), .ovf_o(flags.ovf)
  );

  rtc_alarm #(.SEC_W(DATA_W)) alarm_i (
    .clk_i, .rst_ni, .clear_i(swr_q), .tick_i(tick), .wr_i(wr_alm),
    .wdata_i, .sec_i(sec_w), .alarm_o(alarm_w), .flag_o(flags.alarm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) swr_q <= 1'b0;
    else if (wr_ctrl) swr_q <= wdata_i[CTRL_SWR];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      ien_q       <= '0;
      comp_q      <= '0;
      sec_pulse_q <= 1'b0;
    end else if (swr_q) begin
      en_q        <= 1'b0;
      ien_q       <= '0;
      comp_q      <= '0;
      sec_pulse_q <= 1'b0;
    end else begin
      if (wr_ctrl) en_q   <= wdata_i[CTRL_EN];
      if (wr_ien)  ien_q  <= wdata_i[IEN_W-1:0];
      if (wr_comp) comp_q <= wdata_i;
      sec_pulse_q <= tick && ien_q[IEN_SEC];
    end
  end

  assign irq_o = |({flags.alarm, flags.ovf, flags.inv} & ien_q[2:0]) || sec_pulse_q;

  always_comb begin
    unique case (addr_i)
      A_SEC:   rdata_o = sec_w;
      A_ALM:   rdata_o = alarm_w;
      A_STAT:  rdata_o = DATA_W'(flags);
      A_CTRL:  rdata_o = DATA_W'({swr_q, en_q});
      A_IEN:   rdata_o = DATA_W'(ien_q);
      A_COMP:  rdata_o = comp_q;
      default: rdata_o = '0;
    endcase
  end

  // R8
  swr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr_q |=> (!en_q && ien_q == '0 && comp_q == '0));
  // R8
  swr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swr_q && !wr_ctrl) |=> swr_q);
  // R7
  sec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_q |=> !sec_pulse_q);
endmodule

// File: tb/rtc_sec_core_tb.sv
`timescale 1ns/1ps
module rtc_sec_core_tb_top;
  localparam int PB   = 3;
  localparam int PMAX = (1 << PB) - 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int errors = 0, checks = 0, cyc = 0;
  bit auto_step = 1'b0, done = 1'b0;

  always #2 clk_i = ~clk_i;

  rtc_sec_core #(.PRESC_BITS(PB)) dut_i (.*);

  // behavioural reference
  logic [31:0] m_sec, m_alm, m_comp;
  logic        m_inv, m_ovf, m_alf, m_en, m_swr, m_pulse;
  logic [3:0]  m_ien;
  int          m_presc;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_sec;
      3'd1: return m_alm;
      3'd2: return {29'd0, m_alf, m_ovf, m_inv};
      3'd3: return {30'd0, m_swr, m_en};
      3'd4: return {28'd0, m_ien};
      3'd5: return m_comp;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      m_sec = 0; m_alm = 0; m_comp = 0; m_inv = 1; m_ovf = 0; m_alf = 0;
      m_en = 0; m_swr = 0; m_pulse = 0; m_ien = 0; m_presc = 0;
    end else begin
      bit run, tck, nswr;
      run  = m_en && !m_inv && !m_ovf;
      tck  = run && step_i && m_presc == PMAX;
      nswr = (we_i && addr_i == 3) ? wdata_i[1] : m_swr;
      if (m_swr) begin
        m_sec = 0; m_alm = 0; m_comp = 0; m_inv = 1; m_ovf = 0; m_alf = 0;
        m_en = 0; m_pulse = 0; m_ien = 0; m_presc = 0;
      end else begin
        logic [31:0] old_sec;
        old_sec = m_sec;
        m_presc = !run ? 0 : (step_i ? (m_presc + 1) % (PMAX + 1) : m_presc);
        m_pulse = tck && m_ien[3];
        if (we_i && addr_i == 0 && !m_en) begin
          m_sec = wdata_i; m_inv = 0; m_ovf = 0;
        end else if (tck) begin
          if (m_sec == 32'hFFFF_FFFF) m_ovf = 1;
          m_sec = m_sec + 1;
        end
        if (we_i && addr_i == 1) begin
          m_alm = wdata_i; m_alf = 0;
        end else if (tck && (old_sec + 32'd1) == m_alm) m_alf = 1;
        if (we_i && addr_i == 3) m_en = wdata_i[0];
        if (we_i && addr_i == 4) m_ien = wdata_i[3:0];
        if (we_i && addr_i == 5) m_comp = wdata_i;
      end
      m_swr = nswr;
    end
    #1;
    if (rst_ni && !done) begin
      chk("R10 read vs model", rdata_o, m_read(addr_i));
      chk("R7 irq vs model", {31'd0, irq_o},
          {31'd0, (m_inv && m_ien[0]) || (m_ovf && m_ien[1]) || (m_alf && m_ien[2]) || m_pulse});
    end
  end

  // background timebase
  always @(negedge clk_i) if (auto_step) step_i <= (cyc % 3 != 0);

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i); we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); we_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; #1; d = rdata_o;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); step_i = 1;
    end
    @(negedge clk_i); step_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, s0;
    int pulses;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    rd(0, v); chk("R1 sec", v, 0);
    rd(1, v); chk("R1 alarm", v, 0);
    rd(2, v); chk("R1 status", v, 1);
    rd(3, v); chk("R1 ctrl", v, 0);
    rd(4, v); chk("R1 ien", v, 0);
    rd(5, v); chk("R1 comp", v, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    rd(7, v); chk("R10 unmapped", v, 0);

    // R3: enabled but invalid -> frozen
    wr(3, 1); auto_step = 1; idle(60);
    rd(0, v); chk("R3 frozen while invalid", v, 0);
    // R4: write while enabled is ignored
    wr(0, 32'd77);
    rd(0, v); chk("R4 locked write", v, 0);
    rd(2, v); chk("R4 invalid kept", v, 1);
    // invalid interrupt
    wr(4, 1); chk("R7 inv irq", {31'd0, irq_o}, 1);
    wr(4, 0);

    // R2: exact step count
    auto_step = 0; step_i = 0;
    wr(3, 0); wr(0, 32'd5);
    rd(2, v); chk("R4 load clears invalid", v, 0);
    wr(3, 1);
    steps(PMAX);
    rd(0, v); chk("R2 no tick before full count", v, 5);
    steps(1);
    rd(0, v); chk("R2 tick on last step", v, 6);
    // R2: prescaler cleared while stopped
    steps(3); wr(3, 0); wr(3, 1);
    steps(PMAX);
    rd(0, v); chk("R2 prescaler restarted", v, 6);
    steps(1);
    rd(0, v); chk("R2 tick after restart", v, 7);

    // R3: counting under background steps
    auto_step = 1; idle(100);
    rd(0, v); chk("R3 advanced", {31'd0, v > 32'd7}, 1);

    // R6 alarm + R7
    wr(3, 0); wr(0, 32'd10); wr(1, 32'd12); wr(4, 4); wr(3, 1);
    for (int i = 0; i < 200; i++) begin
      rd(2, v); if (v[2]) break;
    end
    chk("R6 alarm flag", v, 4);
    rd(0, v); chk("R6 count at alarm", v, 12);
    chk("R7 alarm irq", {31'd0, irq_o}, 1);
    wr(1, 32'd500);
    rd(2, v); chk("R6 alarm write clears", v, 0);
    chk("R7 irq drop", {31'd0, irq_o}, 0);

    // R7 seconds pulse, one cycle wide
    wr(4, 8);
    pulses = 0;
    rd(0, s0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i); if (irq_o) pulses++;
    end
    rd(0, v);
    chk("R7 pulse count", pulses, v - s0);
    wr(4, 0);

    // R5 overflow
    wr(3, 0); wr(0, 32'hFFFF_FFFE); wr(4, 2); wr(3, 1);
    for (int i = 0; i < 200; i++) begin
      rd(2, v); if (v[1]) break;
    end
    chk("R5 ovf flag", v, 2);
    rd(0, v); chk("R5 wrapped", v, 0);
    chk("R7 ovf irq", {31'd0, irq_o}, 1);
    idle(60);
    rd(0, v); chk("R5 stays stopped", v, 0);
    wr(3, 0); wr(0, 32'd3);
    rd(2, v); chk("R4 load clears ovf", v, 0);

    // R9 compensation
    wr(5, 32'hA5C3_0F96);
    rd(5, v); chk("R9 comp readback", v, 32'hA5C3_0F96);
    rd(0, v); chk("R9 no effect", v, 3);

    // R8 soft reset
    wr(4, 4'hF); wr(3, 3);
    rd(3, v); chk("R8 swr set, en cleared", v, 2);
    wr(1, 32'd99);
    rd(1, v); chk("R8 alarm write lost", v, 0);
    rd(5, v); chk("R8 comp reset", v, 0);
    rd(4, v); chk("R8 ien reset", v, 0);
    idle(10);
    rd(3, v); chk("R8 swr sticky", v, 2);
    wr(3, 0);
    rd(3, v); chk("R8 swr cleared", v, 0);
    rd(2, v); chk("R8 invalid after swr", v, 1);
    rd(0, v); chk("R8 sec after swr", v, 0);
    wr(1, 32'd42);
    rd(1, v); chk("R8 writes resume", v, 42);

    auto_step = 0;
    idle(5);
    finish_run();
  end
endmodule